// File: doc/BRIEF.md
# Address-Match Breakpoint Comparator

This block watches the instruction fetch stream and the data access stream of a processor core and decides, every cycle, whether one of a small bank of configured address-match triggers has been hit. Each trigger is described by three words held elsewhere in the core: a control word (trigger kind, privilege enables, load/store/execute enables, size code), a target address word, and a context word that can restrict the trigger to one software context. The comparator applies privilege filtering that depends on the trigger kind and on whether the hart is running virtualized. It also applies the context qualifier, an exact address compare for fetches, and a byte-range overlap test for data accesses.

When a trigger hits, the block raises a breakpoint-exception request for one cycle, one clock after the fetch or access was presented. It also gives the index of the trigger that fired and the address that the trap handler should see. The request is meant to stop the instruction or access before it completes. The only action is the breakpoint exception.

Top module: `brk_match_top`

## Requirements
- R1: A trigger of kind 2 (control bits [31:28] equal 2) never fires while the virtualization flag is 1.
- R2: Outside virtualization, a trigger fires only at privilege level p (U=0, S=1, M=3) when control bit 3+p is set. For a kind 6 trigger under virtualization, the enable is control bit 23+p (VU bit 23, VS bit 24).
- R3: A trigger whose load (bit 0), store (bit 1) and execute (bit 2) enables are all clear never fires.
- R4: Only kinds 2 and 6 can fire; any other value in control bits [31:28] never produces a request.
- R5: A fetch hit needs the execute enable and a fetch PC exactly equal to the target word; the reported trap address is then the target word.
- R6: A data hit needs the load enable for a read (write strobe 0) and the store enable for a write (write strobe 1).
- R7: A data hit occurs when any byte of the access overlaps the trigger range [target, target+len). The access length is 1, 2, 4 or 8 bytes for access size code 0..3. For kind 2, len comes from control bits [17:16]: 1→1, 2→2, 0 or 3→4. For kind 6, len comes from bits [19:16]: 1→1, 2→2, 3→4, all others→8.
- R8: When context-word bit 25 is set (select code 4..7), a trigger fires only if context bits [31:26] equal the context input. When bit 25 is clear, the context is ignored.
- R9: When several triggers hit in one cycle, the lowest index is reported. Within one trigger, a fetch hit takes precedence over a data hit. For a data hit, the trap address is the access address.
- R10: The request is registered: it is high in exactly the cycle after a qualifying valid fetch or access. Without a hit it is low, and index and trap address read 0.
- R11: During and right after reset the request, index and trap address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcfg_i | input | NTRIG*XLEN | Control word of each trigger, trigger t at [t*XLEN +: XLEN] |
| taddr_i | input | NTRIG*XLEN | Target address word of each trigger |
| tctx_i | input | NTRIG*XLEN | Context qualifier word of each trigger |
| priv_i | input | 2 | Current privilege level (U=0, S=1, M=3) |
| virt_i | input | 1 | Hart runs virtualized |
| ctx_i | input | CTXW | Current software context value |
| fetch_vld_i | input | 1 | Fetch PC is valid this cycle |
| fetch_pc_i | input | XLEN | Fetch PC |
| acc_vld_i | input | 1 | Data access is valid this cycle |
| acc_wr_i | input | 1 | Access direction, 1 = write |
| acc_addr_i | input | XLEN | Access start address |
| acc_sz_i | input | 2 | Access size code, length 2^code bytes |
| bp_req_o | output | 1 | Breakpoint exception request (one cycle) |
| bp_idx_o | output | clog2(NTRIG) | Index of the trigger that fired |
| bp_tval_o | output | XLEN | Trap address |

## Verification
A behavioural model steps through each trigger in index order and tests byte-by-byte overlap. Its result is compared with the outputs after every clock. Directed patterns place accesses one byte inside and one byte outside each range end, including accesses that start below the target. These patterns separate the default lengths of kind 2 and kind 6 from an off-by-one bound. Privilege and virtualization sweeps with single enable bits set show whether the right bit is consulted for each kind. Collision patterns with a data hit on a low index and a fetch hit on a higher one expose a wrong priority or trap-address source, and long random runs over clustered addresses cover the rest.

// File: rtl/brk_cmp_pkg.sv
package brk_cmp_pkg;

    // control word enables
    localparam int F_LOAD       = 0;
    localparam int F_STORE      = 1;
    localparam int F_EXEC       = 2;
    localparam int F_MODE_BASE  = 3;   // bit 3+p outside virtualization
    localparam int F_VMODE_BASE = 23;  // bit 23+p under virtualization (kind 6)
    localparam int F_SIZE_LSB   = 16;

    localparam logic [3:0] KIND_ADDR  = 4'd2;
    localparam logic [3:0] KIND_ADDR6 = 4'd6;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    // trigger range length in bytes for a size code
    function automatic logic [3:0] span_bytes(input logic is6, input logic [3:0] code);
        logic [3:0] len;
        case (code)
            4'd1:    len = 4'd1;
            4'd2:    len = 4'd2;
            4'd3:    len = 4'd4;
            default: len = is6 ? 4'd8 : 4'd4;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/brk_cfg_decode.sv
module brk_cfg_decode
    import brk_cmp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CTXW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cfg_i,
    input  logic [XLEN-1:0] ext_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic [CTXW-1:0] ctx_i,
    output logic            qual_o,
    output logic [3:0]      span_o
);
    localparam int TYPE_LSB = XLEN - 4;
    localparam int CTX_LSB  = XLEN - CTXW;
    localparam int SEL_MSB  = CTX_LSB - 1;

    logic [3:0] kind;
    logic       is2, is6;
    logic       mode_ok, any_mode, any_op, ctx_ok;
    logic [3:0] size_code;
    logic       unused_cfg, unused_ext;

    assign unused_cfg = ^cfg_i;
    assign unused_ext = ^ext_i;

    always_comb begin
        kind = cfg_i[XLEN-1:TYPE_LSB];
        is2  = (kind == KIND_ADDR);
        is6  = (kind == KIND_ADDR6);

        if (virt_i) begin
            mode_ok = is6 & cfg_i[F_VMODE_BASE + int'(priv_i)];
        end else begin
            mode_ok = cfg_i[F_MODE_BASE + int'(priv_i)];
        end

        any_mode = cfg_i[F_MODE_BASE + int'(PRIV_U)] | cfg_i[F_MODE_BASE + int'(PRIV_S)]
                 | cfg_i[F_MODE_BASE + int'(PRIV_M)]
                 | (is6 & (cfg_i[F_VMODE_BASE] | cfg_i[F_VMODE_BASE + 1]));
        any_op   = cfg_i[F_LOAD] | cfg_i[F_STORE] | cfg_i[F_EXEC];

        ctx_ok = ~ext_i[SEL_MSB] | (ext_i[XLEN-1:CTX_LSB] == ctx_i);

        qual_o = (is2 | is6) & mode_ok & any_mode & any_op & ctx_ok;

        size_code = is6 ? cfg_i[F_SIZE_LSB+3:F_SIZE_LSB]
                        : {2'b00, cfg_i[F_SIZE_LSB+1:F_SIZE_LSB]};
        span_o    = span_bytes(is6, size_code);
    end

    AST_T2_NO_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
        (virt_i && cfg_i[XLEN-1:TYPE_LSB] == KIND_ADDR) |-> !qual_o); // R1

    AST_CTX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_i[SEL_MSB] && ext_i[XLEN-1:CTX_LSB] != ctx_i) |-> !qual_o); // R8

    AST_KIND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[XLEN-1:TYPE_LSB] != KIND_ADDR && cfg_i[XLEN-1:TYPE_LSB] != KIND_ADDR6)
        |-> !qual_o); // R4

endmodule

// File: rtl/brk_hit.sv
module brk_hit
    import brk_cmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      ops_i,
    input  logic [XLEN-1:0] tgt_i,
    input  logic            qual_i,
    input  logic [3:0]      span_i,
    input  logic            fetch_vld_i,
    input  logic [XLEN-1:0] fetch_pc_i,
    input  logic            acc_vld_i,
    input  logic            acc_wr_i,
    input  logic [XLEN-1:0] acc_addr_i,
    input  logic [1:0]      acc_sz_i,
    output logic            x_hit_o,
    output logic            d_hit_o
);
    logic [3:0]      acc_len;
    logic [XLEN-1:0] off_acc, off_tgt;
    logic            dir_ok, overlap;

    always_comb begin
        acc_len = 4'd1 << acc_sz_i;
        off_acc = acc_addr_i - tgt_i;
        off_tgt = tgt_i - acc_addr_i;
        // either the access starts inside the range or the range starts inside the access
        overlap = (off_acc < {{(XLEN-4){1'b0}}, span_i})
                | (off_tgt < {{(XLEN-4){1'b0}}, acc_len});
        dir_ok  = acc_wr_i ? ops_i[F_STORE] : ops_i[F_LOAD];

        x_hit_o = fetch_vld_i & qual_i & ops_i[F_EXEC] & (fetch_pc_i == tgt_i);
        d_hit_o = acc_vld_i & qual_i & dir_ok & overlap;
    end

    AST_EXEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        x_hit_o |-> (fetch_pc_i == tgt_i && fetch_vld_i)); // R5

    AST_WR_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit_o && acc_wr_i) |-> ops_i[F_STORE]); // R6

    AST_RD_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit_o && !acc_wr_i) |-> ops_i[F_LOAD]); // R6

    AST_NO_OPS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ops_i == 3'b000) |-> (!x_hit_o && !d_hit_o)); // R3

endmodule

// File: rtl/brk_pick.sv
module brk_pick #(
    parameter int NTRIG = 4,
    localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] x_hit_i,
    input  logic [NTRIG-1:0] d_hit_i,
    output logic             any_o,
    output logic [IDXW-1:0]  idx_o,
    output logic             from_exec_o
);
    logic [NTRIG-1:0] grant;

    always_comb begin
        any_o       = 1'b0;
        idx_o       = '0;
        from_exec_o = 1'b0;
        grant       = '0;
        // scan from the top so that the lowest hit index is the one left standing
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (x_hit_i[i] || d_hit_i[i]) begin
                any_o       = 1'b1;
                idx_o       = IDXW'(i);
                from_exec_o = x_hit_i[i];
                grant       = '0;
                grant[i]    = 1'b1;
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R9

    AST_WINNER_IF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_hit_i | d_hit_i) != '0) |-> (grant != '0)); // R9

endmodule

// File: rtl/brk_match_top.sv
module brk_match_top
    import brk_cmp_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    parameter int CTXW  = 6,
    localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTRIG*XLEN-1:0] tcfg_i,
    input  logic [NTRIG*XLEN-1:0] taddr_i,
    input  logic [NTRIG*XLEN-1:0] tctx_i,
    input  logic [1:0]            priv_i,
    input  logic                  virt_i,
    input  logic [CTXW-1:0]       ctx_i,
    input  logic                  fetch_vld_i,
    input  logic [XLEN-1:0]       fetch_pc_i,
    input  logic                  acc_vld_i,
    input  logic                  acc_wr_i,
    input  logic [XLEN-1:0]       acc_addr_i,
    input  logic [1:0]            acc_sz_i,
    output logic                  bp_req_o,
    output logic [IDXW-1:0]       bp_idx_o,
    output logic [XLEN-1:0]       bp_tval_o
);
    typedef struct packed {
        logic            req;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] tval;
    } out_t;

    out_t             out_d, out_q;
    logic [NTRIG-1:0] x_hit, d_hit;
    logic             any_hit, from_exec;
    logic [IDXW-1:0]  win_idx;

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        logic       qual;
        logic [3:0] span;

        brk_cfg_decode #(.XLEN(XLEN), .CTXW(CTXW)) i_dec (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_i  (tcfg_i[t*XLEN +: XLEN]),
            .ext_i  (tctx_i[t*XLEN +: XLEN]),
            .priv_i (priv_i),
            .virt_i (virt_i),
            .ctx_i  (ctx_i),
            .qual_o (qual),
            .span_o (span)
        );

        brk_hit #(.XLEN(XLEN)) i_hit (
            .clk         (clk),
            .rst_n       (rst_n),
            .ops_i       (tcfg_i[t*XLEN +: 3]),
            .tgt_i       (taddr_i[t*XLEN +: XLEN]),
            .qual_i      (qual),
            .span_i      (span),
            .fetch_vld_i (fetch_vld_i),
            .fetch_pc_i  (fetch_pc_i),
            .acc_vld_i   (acc_vld_i),
            .acc_wr_i    (acc_wr_i),
            .acc_addr_i  (acc_addr_i),
            .acc_sz_i    (acc_sz_i),
            .x_hit_o     (x_hit[t]),
            .d_hit_o     (d_hit[t])
        );
    end

    brk_pick #(.NTRIG(NTRIG)) i_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .x_hit_i     (x_hit),
        .d_hit_i     (d_hit),
        .any_o       (any_hit),
        .idx_o       (win_idx),
        .from_exec_o (from_exec)
    );

    always_comb begin
        out_d = '0;
        if (any_hit) begin
            out_d.req  = 1'b1;
            out_d.idx  = win_idx;
            out_d.tval = from_exec ? taddr_i[int'(win_idx)*XLEN +: XLEN] : acc_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bp_req_o  = out_q.req;
    assign bp_idx_o  = out_q.idx;
    assign bp_tval_o = out_q.tval;

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld_i && !acc_vld_i) |=> !bp_req_o); // R10

    AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_req_o |-> (bp_idx_o == '0 && bp_tval_o == '0)); // R10

    AST_REQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bp_req_o) |-> $past((x_hit | d_hit) != '0)); // R10

endmodule

// File: tb/test_brk_match_top.sv
`timescale 1ns/1ps
module test_brk_match_top;
    localparam int NT = 4;
    localparam int XL = 32;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] d1 [NT];
    logic [31:0] d2 [NT];
    logic [31:0] d3 [NT];
    logic [NT*XL-1:0] tcfg, taddr, tctx;
    logic [1:0]  priv;
    logic        virt, fvld, avld, awr;
    logic [CW-1:0] ctx;
    logic [31:0] pc, aaddr;
    logic [1:0]  asz;
    logic        req;
    logic [1:0]  idx;
    logic [31:0] tval;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            tcfg[t*XL +: XL]  = d1[t];
            taddr[t*XL +: XL] = d2[t];
            tctx[t*XL +: XL]  = d3[t];
        end
    end

    brk_match_top #(.NTRIG(NT), .XLEN(XL), .CTXW(CW)) i_brk_match_top (
        .clk(clk), .rst_n(rst_n), .tcfg_i(tcfg), .taddr_i(taddr), .tctx_i(tctx),
        .priv_i(priv), .virt_i(virt), .ctx_i(ctx), .fetch_vld_i(fvld), .fetch_pc_i(pc),
        .acc_vld_i(avld), .acc_wr_i(awr), .acc_addr_i(aaddr), .acc_sz_i(asz),
        .bp_req_o(req), .bp_idx_o(idx), .bp_tval_o(tval)
    );

    function automatic logic [31:0] mk(input int kind, input logic [31:0] modes,
                                       input logic [2:0] ops, input int sz);
        return (32'(kind) << 28) | modes | 32'(ops) | (32'(sz) << 16);
    endfunction

    localparam logic [31:0] MU = 32'h8, MS = 32'h10, MM = 32'h40;
    localparam logic [31:0] MVU = 32'h0080_0000, MVS = 32'h0100_0000;

    // behavioural reference: walk triggers in order, byte-by-byte overlap test
    task automatic ref_model(output logic r, output logic [1:0] ix, output logic [31:0] tv);
        bit found = 0;
        r = 0; ix = 0; tv = 0;
        for (int t = 0; t < NT; t++) begin
            int kind = int'(d1[t][31:28]);
            int pv = int'(priv);
            bit pok, cok, dh;
            int len;
            if (found) continue;
            if (kind != 2 && kind != 6) continue;
            if (virt) pok = (kind == 6) ? d1[t][23+pv] : 1'b0;
            else      pok = d1[t][3+pv];
            cok = !d3[t][25] || (d3[t][31:26] == ctx);
            if (!(pok && cok)) continue;
            if (fvld && d1[t][2] && pc == d2[t]) begin
                found = 1; r = 1; ix = 2'(t); tv = d2[t];
                continue;
            end
            if (kind == 2) begin
                case (d1[t][17:16]) 2'd1: len = 1; 2'd2: len = 2; default: len = 4; endcase
            end else begin
                case (d1[t][19:16]) 4'd1: len = 1; 4'd2: len = 2; 4'd3: len = 4; default: len = 8; endcase
            end
            dh = 0;
            if (avld && (awr ? d1[t][1] : d1[t][0])) begin
                for (int b = 0; b < (1 << asz); b++) begin
                    logic [31:0] ba = aaddr + 32'(b);
                    if ((ba - d2[t]) < 32'(len)) dh = 1;
                end
            end
            if (dh) begin
                found = 1; r = 1; ix = 2'(t); tv = aaddr;
            end
        end
    endtask

    task automatic compare(input string tag, input logic er, input logic [1:0] ei,
                           input logic [31:0] et);
        checks++;
        if (req !== er || idx !== ei || tval !== et) begin
            errors++;
            $display("FAIL %s: got req=%0b idx=%0d tval=%h, expected req=%0b idx=%0d tval=%h",
                     tag, req, idx, tval, er, ei, et);
        end
    endtask

    task automatic step(input string tag);
        logic er; logic [1:0] ei; logic [31:0] et;
        ref_model(er, ei, et);
        @(posedge clk);
        @(negedge clk);
        compare(tag, er, ei, et);
    endtask

    task automatic quiet();
        fvld = 0; avld = 0; awr = 0; pc = 0; aaddr = 0; asz = 0;
    endtask

    task automatic clear_trigs();
        for (int t = 0; t < NT; t++) begin
            d1[t] = 0; d2[t] = 0; d3[t] = 0;
        end
    endtask

    task automatic fetch(input logic [31:0] a);
        quiet(); fvld = 1; pc = a;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic [1:0] s);
        quiet(); avld = 1; awr = w; aaddr = a; asz = s;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_trigs(); quiet();
        priv = 2'd3; virt = 0; ctx = 0;
        repeat (3) @(negedge clk);
        compare("R11 reset", 1'b0, 2'd0, 32'h0);
        rst_n = 1;
        @(negedge clk);
        compare("R11 after reset", 1'b0, 2'd0, 32'h0);

        // R5 execute match
        d1[0] = mk(2, MM, 3'b100, 0); d2[0] = 32'h1000;
        fetch(32'h1000); step("R5 exec hit");
        fetch(32'h1004); step("R5 exec miss");
        quiet(); step("R10 idle after hit");

        // R1 kind 2 under virtualization
        virt = 1; priv = 0; d1[0] = mk(2, MU | MVU, 3'b100, 0);
        fetch(32'h1000); step("R1 kind2 virt blocked");
        // R2 kind 6 virtual enables
        d1[0] = mk(6, MVU, 3'b100, 0);
        fetch(32'h1000); step("R2 kind6 VU fires");
        d1[0] = mk(6, MU, 3'b100, 0);
        fetch(32'h1000); step("R2 kind6 virt only U bit");
        priv = 1; d1[0] = mk(6, MVS, 3'b100, 0);
        fetch(32'h1000); step("R2 kind6 VS fires");
        virt = 0; priv = 1; d1[0] = mk(2, MU, 3'b100, 0);
        fetch(32'h1000); step("R2 S level with U bit only");
        d1[0] = mk(2, MS, 3'b100, 0);
        fetch(32'h1000); step("R2 S level with S bit");
        priv = 3;

        // R3 no operation enables
        d1[0] = mk(2, MM, 3'b000, 0);
        fetch(32'h1000); step("R3 no ops exec");
        access(32'h1000, 0, 2); step("R3 no ops read");
        // R4 other kinds
        d1[0] = mk(3, MM, 3'b111, 0);
        fetch(32'h1000); step("R4 kind3 ignored");
        d1[0] = mk(0, MM, 3'b111, 0);
        access(32'h1000, 1, 0); step("R4 kind0 ignored");

        // R6 direction
        d1[0] = mk(2, MM, 3'b010, 0);
        access(32'h1000, 0, 2); step("R6 read with store only");
        access(32'h1000, 1, 2); step("R6 write with store");
        d1[0] = mk(2, MM, 3'b001, 0);
        access(32'h1000, 0, 0); step("R6 read with load");

        // R7 range lengths
        d1[0] = mk(2, MM, 3'b011, 0);
        access(32'h1003, 0, 0); step("R7 kind2 default last byte");
        access(32'h1004, 0, 0); step("R7 kind2 default past end");
        d1[0] = mk(6, MM, 3'b011, 0);
        access(32'h1007, 0, 0); step("R7 kind6 default last byte");
        access(32'h1008, 0, 0); step("R7 kind6 default past end");
        d1[0] = mk(6, MM, 3'b011, 1);
        access(32'h1001, 0, 0); step("R7 size1 next byte");
        d1[0] = mk(6, MM, 3'b011, 4);
        access(32'h1007, 0, 0); step("R7 kind6 code4 as 8");
        d1[0] = mk(2, MM, 3'b011, 2);
        access(32'h0FFE, 1, 2); step("R7 access below overlaps");
        access(32'h0FFE, 1, 1); step("R7 access below ends before");
        access(32'h0FF8, 1, 3); step("R7 eight bytes below miss");
        access(32'h0FF9, 1, 3); step("R7 eight bytes reach target");

        // R8 context
        d1[0] = mk(2, MM, 3'b100, 0); ctx = 6'd5;
        d3[0] = (32'd9 << 26) | (32'd4 << 23);
        fetch(32'h1000); step("R8 context mismatch");
        d3[0] = (32'd5 << 26) | (32'd4 << 23);
        fetch(32'h1000); step("R8 context match");
        d3[0] = (32'd9 << 26) | (32'd3 << 23);
        fetch(32'h1000); step("R8 context ignored");
        d3[0] = 0;

        // R9 priority
        d1[0] = mk(2, MM, 3'b001, 0); d2[0] = 32'h2000;
        d1[1] = mk(2, MM, 3'b100, 0); d2[1] = 32'h3000;
        d1[2] = mk(6, MM, 3'b100, 0); d2[2] = 32'h3000;
        quiet(); fvld = 1; pc = 32'h3000; avld = 1; aaddr = 32'h2002; asz = 0;
        step("R9 low data beats high exec");
        d1[0] = mk(2, MM, 3'b101, 0); d2[0] = 32'h3000;
        aaddr = 32'h3001;
        step("R9 exec before data same trigger");
        d1[0] = 0; fvld = 1; avld = 0;
        step("R9 lower of two exec");
        quiet(); step("R10 idle");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 40 == 0) begin
                for (int t = 0; t < NT; t++) begin
                    int kpick = int'($urandom_range(0, 5));
                    int k = (kpick < 3) ? 2 : (kpick < 5) ? 6 : 3;
                    d1[t] = (32'(k) << 28) | ($urandom() & 32'h018F_005F);
                    d2[t] = 32'h4000 + 32'($urandom_range(0, 12));
                    d3[t] = ($urandom_range(0, 3) == 0)
                          ? ((32'($urandom_range(0, 3)) << 26) | (32'($urandom_range(0, 7)) << 23)) : 0;
                end
            end
            virt = ($urandom_range(0, 3) == 0);
            priv = virt ? 2'($urandom_range(0, 1)) : ((2'($urandom_range(0, 2)) == 2) ? 2'd3 : 2'($urandom_range(0, 1)));
            ctx  = 6'($urandom_range(0, 3));
            fvld = $urandom_range(0, 1) == 1;
            pc   = 32'h4000 + 32'($urandom_range(0, 12));
            avld = $urandom_range(0, 1) == 1;
            awr  = $urandom_range(0, 1) == 1;
            aaddr = 32'h3FF8 + 32'($urandom_range(0, 24));
            asz  = 2'($urandom_range(0, 3));
            step("R9 random mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule